// File: doc/BRIEF.md
# MESI line state controller

This block keeps the coherence state and a dirty flag for every line of a small cache. It applies the four-state MESI rules to requests made by the local core. Each request names a line index and an operation. Operations that the local copy can resolve finish at once. Operations that need the rest of the system wait on a fabric stub: the block raises a fabric command and holds it until the stub answers with a grant or a fail.

A read of a missing line is always installed as Shared. A write to a missing line asks for an exclusive copy, and a write to a Shared line first asks the fabric to invalidate the other copies. If the fabric refuses, the line keeps exactly the state and dirty flag it had, and the response carries a failure flag.

A clean operation records that a Modified line has been written back. It moves the line to Exclusive with the dirty flag cleared. It is the only path by which a line can reach Exclusive, because this block does not handle snoops.

Only one request is in flight at a time. Every accepted request produces exactly one response pulse, which carries the success flag, the resulting state and the dirty flag.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid with its dirty flag clear. `req_ready` is 1, and `fab_req_valid` and `rsp_valid` are 0.
- R2: States are encoded on 2 bits as Invalid=00, Shared=01, Exclusive=10, Modified=11. Operations are encoded as read=00, write=01, clean=10, and code 11 behaves as a read.
- R3: A read of a Shared, Exclusive or Modified line raises no fabric command. `rsp_valid` pulses in the cycle after acceptance with `rsp_ok`=1 and the state and dirty flag unchanged.
- R4: A write to an Exclusive line raises no fabric command and leaves the line Modified with dirty set.
- R5: A write to a Modified line raises no fabric command and leaves it Modified and dirty.
- R6: A write to a Shared line raises fabric command 11 (invalidate others). On a grant the line becomes Modified and dirty.
- R7: A read of an Invalid line raises fabric command 01 (fetch shared). On a grant the line becomes Shared with dirty clear.
- R8: A write to an Invalid line raises fabric command 10 (fetch exclusive). On a grant the line becomes Modified and dirty.
- R9: When the fabric answers with fail, the line keeps its prior state and dirty flag, and the response has `rsp_ok`=0. When grant and fail are both asserted, fail wins.
- R10: From acceptance until the response cycle ends, `req_ready` stays 0. While waiting, `fab_req_valid`, `fab_cmd` and `fab_idx` stay stable until a grant or fail arrives. The response follows in the cycle after that answer.
- R11: A request changes only the line it names. Every other line keeps its state and dirty flag.
- R12: A clean moves a Modified line to Exclusive with dirty cleared. On a line in any other state it changes nothing. It never raises a fabric command and always responds with `rsp_ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_idx | input | IDX_W | Line index of the request |
| req_op | input | 2 | Operation: 00 read, 01 write, 10 clean, 11 read |
| fab_req_valid | output | 1 | Fabric command pending |
| fab_cmd | output | 2 | 01 fetch shared, 10 fetch exclusive, 11 invalidate others |
| fab_idx | output | IDX_W | Line index of the fabric command |
| fab_grant | input | 1 | Fabric accepted the command |
| fab_fail | input | 1 | Fabric refused the command |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_ok | output | 1 | Request succeeded |
| rsp_state | output | 2 | Line state after the request |
| rsp_dirty | output | 1 | Line dirty flag after the request |

## Verification
The bench walks one line through every state. Each step is checked against an independent model, and each fabric answer is delayed by several cycles.

The bench targets failed invalidations and failed fetches. A design that applied the transition anyway would report Modified or Shared where the prior state is expected.

It also sends a grant and a fail together. A design that let the grant win would report success.

Clean is issued on non-Modified lines, where a wrong design would change a state or clear a flag. The reserved operation code is issued on a line that is already valid, where a wrong design might treat it as a write. A design that mixed up line indexes, or dropped or changed the fabric command while waiting, would show up in later reads of other lines and in the per-cycle stability checks.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_e;

    typedef enum logic [1:0] {
        OP_RD  = 2'b00,
        OP_WR  = 2'b01,
        OP_CLN = 2'b10,
        OP_RSV = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        FC_NONE = 2'b00,
        FC_GETS = 2'b01,
        FC_GETX = 2'b10,
        FC_INV  = 2'b11
    } fcmd_e;

    typedef struct packed {
        mesi_e st;
        logic  dirty;
    } line_t;

    localparam line_t LINE_RESET = '{st: ST_I, dirty: 1'b0};

    // Fabric command needed before an operation can complete.
    function automatic fcmd_e need_fabric(mesi_e st, op_e op);
        fcmd_e c;
        c = FC_NONE;
        if (op == OP_WR) begin
            if (st == ST_I)      c = FC_GETX;
            else if (st == ST_S) c = FC_INV;
        end else if (op != OP_CLN) begin
            if (st == ST_I)      c = FC_GETS;
        end
        return c;
    endfunction

    // Result of an operation that completes without the fabric.
    function automatic line_t local_next(line_t cur, op_e op);
        line_t n;
        n = cur;
        if (op == OP_WR) begin
            n.st    = ST_M;
            n.dirty = 1'b1;
        end else if (op == OP_CLN && cur.st == ST_M) begin
            n.st    = ST_E;
            n.dirty = 1'b0;
        end
        return n;
    endfunction

    // Result of a granted fabric command.
    function automatic line_t granted_next(fcmd_e c);
        line_t n;
        if (c == FC_GETS) begin
            n.st    = ST_S;
            n.dirty = 1'b0;
        end else begin
            n.st    = ST_M;
            n.dirty = 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output line_t            rd_line,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_t            wr_line
);
    line_t lines [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= LINE_RESET;
            else if (wr_en && wr_idx == IDX_W'(g))
                q <= wr_line;
        end
        assign lines[g] = q;
    end

    always_comb begin
        rd_line = LINE_RESET;
        if (int'(rd_idx) < NUM_LINES)
            rd_line = lines[rd_idx];
    end
endmodule

// File: rtl/mesi_decide.sv
module mesi_decide
    import mesi_pkg::*;
(
    input  line_t cur,
    input  op_e   op,
    output fcmd_e cmd,
    output line_t nxt
);
    always_comb begin
        cmd = need_fabric(cur.st, op);
        nxt = local_next(cur, op);
    end
endmodule

// File: rtl/mesi_seq.sv
module mesi_seq
    import mesi_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_idx,
    input  line_t            cur_line,
    input  fcmd_e            dec_cmd,
    input  line_t            dec_next,
    output logic             req_ready,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output line_t            wr_line,
    output logic             fab_req_valid,
    output fcmd_e            fab_cmd,
    output logic [IDX_W-1:0] fab_idx,
    input  logic             fab_grant,
    input  logic             fab_fail,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output line_t            rsp_line
);
    typedef enum logic [1:0] {FS_IDLE, FS_WAIT, FS_RESP} fsm_e;

    fsm_e             fsm;
    line_t            prior_q;
    fcmd_e            cmd_q;
    logic [IDX_W-1:0] idx_q;
    logic             accept;
    logic             answered;

    assign req_ready     = (fsm == FS_IDLE);
    assign accept        = req_valid && req_ready;
    assign answered      = (fsm == FS_WAIT) && (fab_grant || fab_fail);
    assign fab_req_valid = (fsm == FS_WAIT);
    assign fab_cmd       = cmd_q;
    assign fab_idx       = idx_q;
    assign rsp_valid     = (fsm == FS_RESP);

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = req_idx;
        wr_line = dec_next;
        if (accept && dec_cmd == FC_NONE) begin
            wr_en = 1'b1;
        end else if (answered && !fab_fail) begin
            wr_en   = 1'b1;
            wr_idx  = idx_q;
            wr_line = granted_next(cmd_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm      <= FS_IDLE;
            prior_q  <= LINE_RESET;
            cmd_q    <= FC_NONE;
            idx_q    <= '0;
            rsp_ok   <= 1'b0;
            rsp_line <= LINE_RESET;
        end else begin
            case (fsm)
                FS_IDLE: if (accept) begin
                    if (dec_cmd == FC_NONE) begin
                        rsp_ok   <= 1'b1;
                        rsp_line <= dec_next;
                        fsm      <= FS_RESP;
                    end else begin
                        prior_q <= cur_line;
                        cmd_q   <= dec_cmd;
                        idx_q   <= req_idx;
                        fsm     <= FS_WAIT;
                    end
                end
                FS_WAIT: if (answered) begin
                    rsp_ok   <= !fab_fail;
                    rsp_line <= fab_fail ? prior_q : granted_next(cmd_q);
                    fsm      <= FS_RESP;
                end
                default: fsm <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [1:0]       req_op,
    output logic             fab_req_valid,
    output logic [1:0]       fab_cmd,
    output logic [IDX_W-1:0] fab_idx,
    input  logic             fab_grant,
    input  logic             fab_fail,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic [1:0]       rsp_state,
    output logic             rsp_dirty
);
    line_t            cur_line, dec_next, wr_line, rsp_line;
    fcmd_e            dec_cmd, fab_cmd_e;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    mesi_line_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (req_idx),
        .rd_line (cur_line),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_line (wr_line)
    );

    mesi_decide u_decide (
        .cur (cur_line),
        .op  (op_e'(req_op)),
        .cmd (dec_cmd),
        .nxt (dec_next)
    );

    mesi_seq #(.IDX_W(IDX_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_idx       (req_idx),
        .cur_line      (cur_line),
        .dec_cmd       (dec_cmd),
        .dec_next      (dec_next),
        .req_ready     (req_ready),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_line       (wr_line),
        .fab_req_valid (fab_req_valid),
        .fab_cmd       (fab_cmd_e),
        .fab_idx       (fab_idx),
        .fab_grant     (fab_grant),
        .fab_fail      (fab_fail),
        .rsp_valid     (rsp_valid),
        .rsp_ok        (rsp_ok),
        .rsp_line      (rsp_line)
    );

    assign fab_cmd   = fab_cmd_e;
    assign rsp_state = rsp_line.st;
    assign rsp_dirty = rsp_line.dirty;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             fab_req_valid,
    input logic [1:0]       fab_cmd,
    input logic [IDX_W-1:0] fab_idx,
    input logic             fab_grant,
    input logic             fab_fail,
    input logic             rsp_valid,
    input logic             rsp_ok,
    input logic [1:0]       rsp_state,
    input logic             rsp_dirty
);
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> req_ready && !fab_req_valid && !rsp_valid);

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    a_r10_no_accept_while_waiting: assert property (@(posedge clk) disable iff (rst)
        fab_req_valid |-> !req_ready);

    a_r10_fab_hold: assert property (@(posedge clk) disable iff (rst)
        fab_req_valid && !fab_grant && !fab_fail |=>
            fab_req_valid && $stable(fab_cmd) && $stable(fab_idx));

    a_r10_fab_cmd_nonzero: assert property (@(posedge clk) disable iff (rst)
        fab_req_valid |-> fab_cmd != 2'b00);

    a_r9_fail_reports: assert property (@(posedge clk) disable iff (rst)
        fab_req_valid && fab_fail |=> rsp_valid && !rsp_ok);

    a_r6_grant_reports: assert property (@(posedge clk) disable iff (rst)
        fab_req_valid && fab_grant && !fab_fail |=> rsp_valid && rsp_ok);

    a_r5_modified_is_dirty: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_state == 2'b11 |-> rsp_dirty);

    a_r12_shared_or_invalid_clean: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && (rsp_state == 2'b01 || rsp_state == 2'b00) |-> !rsp_dirty);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid && req_ready);
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .fab_req_valid (fab_req_valid),
    .fab_cmd       (fab_cmd),
    .fab_idx       (fab_idx),
    .fab_grant     (fab_grant),
    .fab_fail      (fab_fail),
    .rsp_valid     (rsp_valid),
    .rsp_ok        (rsp_ok),
    .rsp_state     (rsp_state),
    .rsp_dirty     (rsp_dirty)
);

// File: tb/mesi_line_ctrl_bench.sv
module mesi_line_ctrl_bench;
    localparam int NL = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [IW-1:0] req_idx = '0;
    logic [1:0]    req_op = 2'b00;
    logic          fab_req_valid;
    logic [1:0]    fab_cmd;
    logic [IW-1:0] fab_idx;
    logic          fab_grant = 1'b0;
    logic          fab_fail = 1'b0;
    logic          rsp_valid;
    logic          rsp_ok;
    logic [1:0]    rsp_state;
    logic          rsp_dirty;

    always #5 clk = ~clk;

    mesi_line_ctrl #(.NUM_LINES(NL)) u_mesi_line_ctrl (.*);

    typedef struct {
        logic [3:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   vectors = 0;
    int   errors  = 0;
    int   cycles  = 0;
    logic [1:0] m_st [NL];
    logic       m_dirty [NL];

    task automatic chk(string tag, int got, int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // Monitor: response = {ok, state, dirty}
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, {rsp_ok, rsp_state, rsp_dirty}, e.val);
            end
        end
    end

    // act: 0 grant, 1 fail, 2 grant and fail together
    task automatic do_req(int idx, logic [1:0] op, int act, int hold, string tag);
        logic [1:0] c, ns;
        logic       nd, ok;
        logic       wr;
        wr = (op == 2'b01);
        c  = 2'b00;
        if (wr && m_st[idx] == 2'b00)       c = 2'b10;
        else if (wr && m_st[idx] == 2'b01)  c = 2'b11;
        else if (op != 2'b10 && !wr && m_st[idx] == 2'b00) c = 2'b01;
        ok = 1'b1; ns = m_st[idx]; nd = m_dirty[idx];
        if (c != 2'b00) begin
            if (act != 0) ok = 1'b0;
            else if (c == 2'b01) begin ns = 2'b01; nd = 1'b0; end
            else begin ns = 2'b11; nd = 1'b1; end
        end else if (wr) begin
            ns = 2'b11; nd = 1'b1;
        end else if (op == 2'b10 && m_st[idx] == 2'b11) begin
            ns = 2'b10; nd = 1'b0;
        end

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_idx = IW'(idx); req_op = op;
        exp_q.push_back('{val: {ok, ns, nd}, tag: tag});
        @(negedge clk);
        req_valid = 1'b0;
        if (c == 2'b00) begin
            chk({tag, " no fabric"}, fab_req_valid, 0);
        end else begin
            chk({tag, " fabric cmd"}, {fab_req_valid, fab_cmd, fab_idx}, {1'b1, c, IW'(idx)});
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                chk("R10 hold while waiting", {req_ready, fab_req_valid, fab_cmd, fab_idx},
                    {1'b0, 1'b1, c, IW'(idx)});
            end
            fab_grant = (act != 1);
            fab_fail  = (act != 0);
            @(negedge clk);
            fab_grant = 1'b0; fab_fail = 1'b0;
        end
        m_st[idx] = ns; m_dirty[idx] = nd;
    endtask

    initial begin
        for (int i = 0; i < NL; i++) begin m_st[i] = 2'b00; m_dirty[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset ready/fab/rsp", {req_ready, fab_req_valid, rsp_valid}, 3'b100);

        do_req(0,  2'b00, 1, 1, "R1 R9 read invalid line 0 fail");
        do_req(3,  2'b00, 0, 2, "R7 R2 read miss installs shared");
        do_req(3,  2'b00, 0, 0, "R3 read hit shared");
        do_req(3,  2'b10, 0, 0, "R12 clean on shared no change");
        do_req(3,  2'b01, 1, 3, "R9 invalidate fail keeps shared");
        do_req(3,  2'b01, 0, 1, "R6 invalidate grant gives modified");
        do_req(3,  2'b01, 0, 0, "R5 write modified");
        do_req(3,  2'b00, 0, 0, "R3 read hit modified");
        do_req(3,  2'b10, 0, 0, "R12 clean modified to exclusive");
        do_req(3,  2'b11, 0, 0, "R2 R3 reserved op reads exclusive");
        do_req(3,  2'b01, 0, 0, "R4 write exclusive");
        do_req(5,  2'b01, 1, 0, "R9 fetch exclusive fail keeps invalid");
        do_req(5,  2'b01, 2, 4, "R9 grant with fail counts as fail");
        do_req(5,  2'b01, 0, 2, "R8 write miss grant modified");
        do_req(5,  2'b10, 0, 0, "R12 clean line 5");
        do_req(7,  2'b10, 0, 0, "R12 clean invalid no change");
        do_req(3,  2'b00, 0, 0, "R11 line 3 untouched by others");
        do_req(15, 2'b00, 0, 5, "R7 top index read miss");
        do_req(14, 2'b00, 1, 0, "R11 neighbour still invalid");
        do_req(15, 2'b01, 2, 1, "R9 top index invalidate both answers");
        do_req(15, 2'b01, 0, 0, "R6 top index invalidate grant");
        do_req(5,  2'b00, 0, 0, "R11 line 5 keeps exclusive");
        do_req(0,  2'b01, 0, 0, "R8 line 0 write miss no delay");

        repeat (4) @(negedge clk);
        chk("R10 all responses seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule